// File: doc/BRIEF.md
# Two-Way I2C Downstream Channel Selector

This block is an I2C target with a single control byte. The byte decides which of two downstream bus segments is joined to the upstream bus. The block samples the upstream clock and data lines and resynchronizes them into the system clock. It finds START and STOP conditions and answers one fixed 7-bit address. A write transfer stores the data byte in the control register. A read transfer returns the stored byte.

The enable outputs do not follow a write at once. They are refreshed from the control register only when a STOP appears on the upstream bus. As a result, a segment is never joined or split while a transfer is running.

The enable outputs are plain level signals that would drive external pass switches. The data line is open-drain: `sda_oe` high means the block pulls SDA low. The block has no streaming data path, so there is no valid/ready handshake; every pin is a plain control or bus-line pin.

Top module: `i2c_chsel_mux`

## Requirements
- R1: After reset, `ch_en` is 2'b00, `sda_oe` is 0, and the control byte reads back as 8'h00.
- R2: The block pulls SDA low during the ninth clock of an address byte only when the 7 address bits equal 7'b1110000. Any other address gets no acknowledge, and the control byte is left unchanged.
- R3: After a matched address with direction bit 0, the next byte is stored in the control register and acknowledged by pulling SDA low during its ninth clock.
- R4: `ch_en` changes only when a STOP condition (SDA rising while SCL is high) is detected. A write on its own leaves `ch_en` as it was until that STOP.
- R5: At a STOP, `ch_en` is decoded from control bits [2:0]:
  - 3'b100 gives 2'b01.
  - 3'b101 gives 2'b10.
  - Any value with bit 2 clear gives 2'b00.
  - Bits [2:1] = 2'b11 give 2'b00.
  - Bits [7:3] have no effect.
- R6: After a matched address with direction bit 1, the block shifts out the control byte MSB first. SDA changes only while SCL is low. `sda_oe` is 0 during the acknowledge clock that follows the byte. If the controller acknowledges, the byte is sent again.
- R7: A repeated START (SDA falling while SCL is high, in the middle of a transfer) restarts address reception and does not update `ch_en`.
- R8: At most one bit of `ch_en` is ever high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Upstream SCL line level |
| sda_i | input | 1 | Upstream SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | High pulls upstream SDA low |
| ch_en | output | 2 | One-hot enable for downstream channels 0 and 1 |

## Verification
The bench targets the following corner cases:
- **Deferred switch.** It checks `ch_en` between the acknowledge of a write and the STOP. A design that switched early would show the new channel there.
- **Repeated START.** It writes a byte, then reads it back after a repeated START. An enable that followed any bus condition would change before the real STOP.
- **Decode values.** It covers the reserved code with bits [2:1] set, and values with the upper bits set. A decoder that looked only at bit 0, or used the upper bits, would enable a channel.
- **Foreign addresses.** Random transfers to other addresses must draw no acknowledge and leave the read-back value untouched. A loose comparator would store bytes meant for another target.

// File: rtl/i2c_chsel_pkg.sv
package i2c_chsel_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  // Bus lines idle high, so every stage resets to 1.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_p[g] <= 1'b1;
          sda_p[g] <= 1'b1;
        end else begin
          scl_p[g] <= scl_i;
          sda_p[g] <= sda_i;
        end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_p[g] <= 1'b1;
          sda_p[g] <= 1'b1;
        end else begin
          scl_p[g] <= scl_p[g-1];
          sda_p[g] <= sda_p[g-1];
        end
    end
  end

  assign scl_s = scl_p[STAGES-1];
  assign sda_s = sda_p[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_chsel_pkg::*;
#(
  parameter logic [6:0] ADDR = 7'b1110000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              sda_oe,
  output logic              idle
);
  slv_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              byte_done, rw, m_ack;

  assign wr_byte = shreg;
  assign idle    = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      rw        <= 1'b0;
      m_ack     <= 1'b0;
      sda_oe    <= 1'b0;
      wr_stb    <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        byte_done <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        byte_done <= 1'b0;
        sda_oe    <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WDAT: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == CNT_W'(BYTE_W - 1)) byte_done <= 1'b1;
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              if (state == ST_WDAT) begin
                wr_stb <= 1'b1;
                sda_oe <= 1'b1;
                state  <= ST_WACK;
              end else if (shreg[BYTE_W-1:1] == ADDR) begin
                rw     <= shreg[0];
                sda_oe <= 1'b1;
                state  <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK, ST_WACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (state == ST_AACK && rw) begin
                shreg  <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WDAT;
              end
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe  <= ~shreg[BYTE_W-2];
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                shreg   <= rd_byte;
                sda_oe  <= ~rd_byte[BYTE_W-1];
                bit_cnt <= '0;
                state   <= ST_RDAT;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/chsel_decode.sv
module chsel_decode #(
  parameter int NCH   = 2,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W:0]   ctrl,
  output logic [NCH-1:0]   en
);
  localparam int EN_BIT = SEL_W;

  // An index outside 0..NCH-1 enables nothing.
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign en[i] = ctrl[EN_BIT] && (ctrl[SEL_W-1:0] == SEL_W'(i));
  end
endmodule

// File: rtl/i2c_chsel_mux.sv
module i2c_chsel_mux
  import i2c_chsel_pkg::*;
#(
  parameter logic [6:0] ADDR        = 7'b1110000,
  parameter int         NCH         = 2,
  parameter int         SEL_W       = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe,
  output logic [NCH-1:0] ch_en
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb, slv_idle;
  logic [BYTE_W-1:0] wr_byte, ctrl_q;
  logic [NCH-1:0]    dec_en;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_s, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det
  );

  i2c_slave_fsm #(.ADDR(ADDR)) u_fsm (
    .clk, .rst_n, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
    .rd_byte(ctrl_q), .wr_stb, .wr_byte, .sda_oe, .idle(slv_idle)
  );

  chsel_decode #(.NCH(NCH), .SEL_W(SEL_W)) u_dec (
    .ctrl(ctrl_q[SEL_W:0]), .en(dec_en)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctrl_q <= '0;
    else if (wr_stb) ctrl_q <= wr_byte;

  // The selection is applied only at a STOP, so no segment switches mid-transfer.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ch_en <= '0;
    else if (stop_det) ch_en <= dec_en;
endmodule

// File: rtl/i2c_chsel_mux_chk.sv
module i2c_chsel_mux_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           scl_s,
  input logic           stop_det,
  input logic           slv_idle,
  input logic           sda_oe,
  input logic [NCH-1:0] ch_en
);
  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_en));

  // R4 and R7: without a STOP, the enables hold their value.
  assert_hold_no_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_det |=> $stable(ch_en));

  assert_oe_rise_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slv_idle |-> !sda_oe);
endmodule

bind i2c_chsel_mux i2c_chsel_mux_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .slv_idle(slv_idle), .sda_oe(sda_oe), .ch_en(ch_en)
);

// File: tb/sim_i2c_chsel_mux.sv
`timescale 1ns/1ps
module sim_i2c_chsel_mux;
  localparam int Q = 6;
  localparam logic [6:0] MY_ADDR = 7'b1110000;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, last_oe, done = 1'b0;
  logic [1:0] ch_en;
  wire sda_line = m_sda & ~sda_oe;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  i2c_chsel_mux u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                    .sda_oe(sda_oe), .ch_en(ch_en));

  function automatic logic [1:0] exp_en(input logic [7:0] b);
    if (b[2] && !b[1]) return b[0] ? 2'b10 : 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    if (scl == 1'b0) begin
      m_sda = 1'b1; waitq(); scl = 1'b1; waitq();
    end
    m_sda = 1'b0; waitq(); scl = 1'b0; waitq();
  endtask

  task automatic do_stop();
    m_sda = 1'b0; waitq(); scl = 1'b1; waitq(); m_sda = 1'b1; waitq(); waitq();
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b; waitq(); scl = 1'b1; waitq();
    r = sda_line; last_oe = sda_oe;
    waitq(); scl = 1'b0; waitq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      v[i] = r;
    end
    clk_bit(~give_ack, r);
    chk("R6 sda released in ack clock", {31'd0, last_oe}, 0);
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] d,
                        output logic aa, output logic da);
    do_start();
    wr_byte({a, 1'b0}, aa);
    wr_byte(d, da);
  endtask

  task automatic rd_txn(input int nbytes, output logic aa, output logic [7:0] v);
    logic [7:0] first;
    do_start();
    wr_byte({MY_ADDR, 1'b1}, aa);
    first = 8'h00;
    for (int i = 0; i < nbytes; i++) begin
      rd_byte(i != nbytes - 1, v);
      if (i == 0) first = v;
      else chk("R6 repeated byte equals first", {24'd0, v}, {24'd0, first});
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic aa, da;
    logic [7:0] v, model, d;
    logic [6:0] a;
    logic wrong;
    int unused_seed;
    unused_seed = $urandom(32'h5EED1234);

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    waitq();
    chk("R1 ch_en after reset", {30'd0, ch_en}, 0);
    chk("R1 sda_oe after reset", {31'd0, sda_oe}, 0);
    rd_txn(1, aa, v); do_stop();
    chk("R2 read address ack", {31'd0, aa}, 1);
    chk("R1 control reads zero", {24'd0, v}, 0);

    // Deferred apply: channel 0
    wr_txn(MY_ADDR, 8'h04, aa, da);
    chk("R2 address ack", {31'd0, aa}, 1);
    chk("R3 data ack", {31'd0, da}, 1);
    chk("R4 ch_en held before stop", {30'd0, ch_en}, 0);
    do_stop();
    chk("R5 code 100 -> ch0", {30'd0, ch_en}, 2'b01);

    // Repeated START does not apply; STOP does
    wr_txn(MY_ADDR, 8'h05, aa, da);
    chk("R4 ch_en held after write", {30'd0, ch_en}, 2'b01);
    rd_txn(1, aa, v);
    chk("R7 read after repeated start acked", {31'd0, aa}, 1);
    chk("R6 read back value", {24'd0, v}, 8'h05);
    chk("R7 ch_en unchanged by repeated start", {30'd0, ch_en}, 2'b01);
    do_stop();
    chk("R7 ch_en applied at real stop", {30'd0, ch_en}, 2'b10);

    // Foreign address
    wr_txn(7'h71, 8'h04, aa, da);
    do_stop();
    chk("R2 foreign address not acked", {31'd0, aa}, 0);
    chk("R2 ch_en unchanged", {30'd0, ch_en}, 2'b10);
    rd_txn(2, aa, v); do_stop();
    chk("R2 control byte unchanged", {24'd0, v}, 8'h05);

    // Decode corner values
    wr_txn(MY_ADDR, 8'h06, aa, da); do_stop();
    chk("R5 code 110 -> none", {30'd0, ch_en}, 0);
    wr_txn(MY_ADDR, 8'hFD, aa, da); do_stop();
    chk("R5 upper bits ignored, 101 -> ch1", {30'd0, ch_en}, 2'b10);
    wr_txn(MY_ADDR, 8'hF9, aa, da); do_stop();
    chk("R5 bit2 clear -> none", {30'd0, ch_en}, 0);
    wr_txn(MY_ADDR, 8'hFC, aa, da); do_stop();
    chk("R5 upper bits ignored, 100 -> ch0", {30'd0, ch_en}, 2'b01);
    model = 8'hFC;

    // Constrained random
    for (int it = 0; it < 40; it++) begin
      d = 8'($urandom);
      if (it % 3 == 0) d[2] = 1'b1;
      wrong = ($urandom % 4) == 0;
      a = wrong ? (MY_ADDR ^ 7'(($urandom % 127) + 1)) : MY_ADDR;
      wr_txn(a, d, aa, da);
      chk("R2 random address ack", {31'd0, aa}, {31'd0, ~wrong});
      if (!wrong) chk("R3 random data ack", {31'd0, da}, 1);
      chk("R4 random ch_en before stop", {30'd0, ch_en}, {30'd0, exp_en(model)});
      do_stop();
      if (!wrong) model = d;
      chk("R5 random ch_en after stop", {30'd0, ch_en}, {30'd0, exp_en(model)});
      rd_txn((it % 2) + 1, aa, v); do_stop();
      chk("R6 random read back", {24'd0, v}, {24'd0, model});
      chk("R8 one-hot enables", {31'd0, ch_en != 2'b11}, 1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule